// File: doc/BRIEF.md
# CAN Bit-Time Timestamp Timer

This block keeps the time base of a CAN controller. A 16-bit counter advances by one on each bit-time tick while the controller is enabled. Several conditions clear it: reset, low-power mode, a disabled controller, a software strobe, and, in time-triggered operation, a message accepted by the last mailbox. On a frame boundary the block copies the counter into a timestamp register. The boundary is either the start or the end of a frame, chosen by a mode bit.

Two sticky flags record a counter wrap and a timestamp capture. A status-read strobe clears both flags. The interrupt line combines the two flags through their mask bits. An optional freeze mode holds the counter at all-ones so that a node with a longer time base can restart it. A compare output tells the mailbox logic when the counter reaches a programmed trigger value.

Top module: `can_bit_timer`

## Requirements
- R1: After reset is released, the counter increments by exactly one on each cycle in which `bit_tick` is high, `ctrl_en` is high and no clear condition is present. The new value is visible one clock later.
- R2: While `ctrl_en` is low or `lp_mode` is high, the counter is 0 from the next clock on.
- R3: A `sw_rst` pulse clears the counter on the next clock. This holds even when `bit_tick` is high in the same cycle.
- R4: When `tt_mode` is 1, a rising edge of `lastmb_rdy` (low in the previous cycle, high now) clears the counter. When `tt_mode` is 0, that edge has no effect.
- R5: With `freeze_en` at 0, a tick at FFFFh wraps the counter to 0000h and sets `ovf_flag` on the same clock.
- R6: With `freeze_en` at 1, a tick at FFFFh leaves the counter at FFFFh and sets `ovf_flag` once. Later ticks keep it at FFFFh without setting the flag again. Any clear condition restarts counting from 0.
- R7: When `cap_eof` is 0, an `sof_pulse` copies the counter value held before that clock into `stamp_val`. When `cap_eof` is 1, an `eof_pulse` does the copy instead. The pulse that is not selected is ignored. Each copy sets `ts_flag`. When a capture and a clear happen together, the capture takes the pre-clear value.
- R8: A `status_rd` pulse clears `ovf_flag` and `ts_flag` on the next clock. A flag whose setting event arrives in the same cycle as the read stays set.
- R9: `irq` equals (`ovf_flag` AND `ovf_irq_en`) OR (`ts_flag` AND `ts_irq_en`) in every cycle.
- R10: When `tt_mode` is 1, `trig_hit` is high for exactly the one cycle in which the counter has just advanced by a tick (increment or wrap) to `trig_value`. Reaching 0 through a clear does not count.
- R11: While `rst_n` is low, the counter, `stamp_val`, both flags, `irq` and `trig_hit` are all 0. Release of `rst_n` takes effect internally two clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per CAN bit time |
| ctrl_en | input | 1 | Controller enable; low holds the counter at 0 |
| lp_mode | input | 1 | Low-power mode; high holds the counter at 0 |
| sw_rst | input | 1 | Software timer reset strobe |
| lastmb_rdy | input | 1 | Ready level of the last mailbox |
| sof_pulse | input | 1 | Start-of-frame event |
| eof_pulse | input | 1 | End-of-frame event |
| status_rd | input | 1 | Status register read strobe |
| freeze_en | input | 1 | Hold at all-ones instead of wrapping |
| cap_eof | input | 1 | 1: capture at end of frame, 0: at start of frame |
| tt_mode | input | 1 | 1: time-triggered, 0: timestamping |
| ovf_irq_en | input | 1 | Overflow interrupt mask |
| ts_irq_en | input | 1 | Timestamp interrupt mask |
| trig_value | input | 16 | Mailbox trigger compare value |
| timer_val | output | 16 | Live counter |
| stamp_val | output | 16 | Captured timestamp |
| ovf_flag | output | 1 | Overflow status flag |
| ts_flag | output | 1 | Timestamp status flag |
| irq | output | 1 | Masked interrupt request |
| trig_hit | output | 1 | Trigger match pulse |

## Verification
The hardest states to reach are the ones at the top of the count range: the wrap, the frozen hold at FFFFh, and the single overflow flag that freeze produces. Random clear conditions keep the counter far below those values. The bench therefore runs two directed stretches of 65536 back-to-back ticks with all clears held off, first without freeze and then with it. In the frozen state it adds extra ticks, a status read, and a software restart. Random stimulus covers the rest, with frequent clears so that small trigger values are crossed often. A cycle-level reference model checks every output on every cycle.

// File: rtl/cts_pkg.sv
package cts_pkg;
  localparam int unsigned CTS_TW = 16;
  typedef enum logic {CAP_AT_SOF = 1'b0, CAP_AT_EOF = 1'b1} cap_sel_e;
endpackage

// File: rtl/cts_counter.sv
module cts_counter #(
  parameter int unsigned TW = cts_pkg::CTS_TW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic          lp,
  input  logic          sw_rst,
  input  logic          tt_mode,
  input  logic          lastmb_rdy,
  input  logic          freeze,
  output logic [TW-1:0] cnt_q,
  output logic [TW-1:0] cnt_d,
  output logic          adv,
  output logic          ovf_evt
);
  localparam logic [TW-1:0] MAXV = {TW{1'b1}};

  logic halt_q, halt_d;
  logic rdy_q;
  logic mb_rise, clr;

  assign mb_rise = lastmb_rdy & ~rdy_q;
  assign clr     = ~en | lp | sw_rst | (tt_mode & mb_rise);

  always_comb begin
    cnt_d   = cnt_q;
    halt_d  = halt_q;
    adv     = 1'b0;
    ovf_evt = 1'b0;
    if (clr) begin
      cnt_d  = '0;
      halt_d = 1'b0;
    end else if (tick) begin
      if (cnt_q == MAXV) begin
        if (freeze) begin
          if (!halt_q) begin
            ovf_evt = 1'b1;
            halt_d  = 1'b1;
          end
        end else begin
          cnt_d   = '0;
          adv     = 1'b1;
          ovf_evt = 1'b1;
          halt_d  = 1'b0;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
        adv   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      halt_q <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      halt_q <= halt_d;
      rdy_q  <= lastmb_rdy;
    end
  end

  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && en && !lp && !sw_rst && !(tt_mode && lastmb_rdy && !rdy_q) && cnt_q != MAXV)
    |=> cnt_q == TW'($past(cnt_q) + 1'b1));
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || lp) |=> cnt_q == '0);
  a_r3_swrst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> cnt_q == '0);
  a_r6_frozen_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && cnt_q == MAXV && en && !lp && !sw_rst && !(tt_mode && lastmb_rdy && !rdy_q))
    |=> cnt_q == MAXV);
endmodule

// File: rtl/cts_flags.sv
module cts_flags #(
  parameter int unsigned TW = cts_pkg::CTS_TW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] cnt_q,
  input  logic          sof,
  input  logic          eof,
  input  logic          cap_eof,
  input  logic          ovf_evt,
  input  logic          status_rd,
  input  logic          ovf_msk,
  input  logic          ts_msk,
  output logic [TW-1:0] stamp_q,
  output logic          ovf_q,
  output logic          ts_q,
  output logic          irq
);
  import cts_pkg::*;

  cap_sel_e      sel;
  logic          cap;
  logic [TW-1:0] stamp_d;
  logic          ovf_d, ts_d;

  assign sel = cap_sel_e'(cap_eof);

  always_comb begin
    unique case (sel)
      CAP_AT_EOF: cap = eof;
      default:    cap = sof;
    endcase
    stamp_d = cap ? cnt_q : stamp_q;
    ovf_d   = ovf_evt | (ovf_q & ~status_rd);
    ts_d    = cap | (ts_q & ~status_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stamp_q <= '0;
      ovf_q   <= 1'b0;
      ts_q    <= 1'b0;
    end else begin
      stamp_q <= stamp_d;
      ovf_q   <= ovf_d;
      ts_q    <= ts_d;
    end
  end

  assign irq = (ovf_q & ovf_msk) | (ts_q & ts_msk);

  a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ((cap_eof && eof) || (!cap_eof && sof)) |=> stamp_q == $past(cnt_q) && ts_q);
  a_r5_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_q);
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !ovf_evt) |=> !ovf_q);
endmodule

// File: rtl/cts_trigger.sv
module cts_trigger #(
  parameter int unsigned TW = cts_pkg::CTS_TW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tt_mode,
  input  logic          adv,
  input  logic [TW-1:0] cnt_d,
  input  logic [TW-1:0] trig_val,
  output logic          hit_q
);
  logic hit_d;

  assign hit_d = tt_mode & adv & (cnt_d == trig_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit_d;
  end

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |=> !hit_q);
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int unsigned TW = cts_pkg::CTS_TW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic          ctrl_en,
  input  logic          lp_mode,
  input  logic          sw_rst,
  input  logic          lastmb_rdy,
  input  logic          sof_pulse,
  input  logic          eof_pulse,
  input  logic          status_rd,
  input  logic          freeze_en,
  input  logic          cap_eof,
  input  logic          tt_mode,
  input  logic          ovf_irq_en,
  input  logic          ts_irq_en,
  input  logic [TW-1:0] trig_value,
  output logic [TW-1:0] timer_val,
  output logic [TW-1:0] stamp_val,
  output logic          ovf_flag,
  output logic          ts_flag,
  output logic          irq,
  output logic          trig_hit
);
  localparam int unsigned SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_int_n;
  logic [TW-1:0]     cnt_q, cnt_d;
  logic              adv, ovf_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_N-1];

  cts_counter #(.TW(TW)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .tick(bit_tick), .en(ctrl_en), .lp(lp_mode),
    .sw_rst(sw_rst), .tt_mode(tt_mode), .lastmb_rdy(lastmb_rdy), .freeze(freeze_en),
    .cnt_q(cnt_q), .cnt_d(cnt_d), .adv(adv), .ovf_evt(ovf_evt)
  );

  cts_flags #(.TW(TW)) u_flg (
    .clk(clk), .rst_n(rst_int_n), .cnt_q(cnt_q), .sof(sof_pulse), .eof(eof_pulse),
    .cap_eof(cap_eof), .ovf_evt(ovf_evt), .status_rd(status_rd),
    .ovf_msk(ovf_irq_en), .ts_msk(ts_irq_en),
    .stamp_q(stamp_val), .ovf_q(ovf_flag), .ts_q(ts_flag), .irq(irq)
  );

  cts_trigger #(.TW(TW)) u_trg (
    .clk(clk), .rst_n(rst_int_n), .tt_mode(tt_mode), .adv(adv), .cnt_d(cnt_d),
    .trig_val(trig_value), .hit_q(trig_hit)
  );

  assign timer_val = cnt_q;

  a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq |-> ((ovf_flag && ovf_irq_en) || (ts_flag && ts_irq_en)));
  a_r11_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (timer_val == '0 && !ovf_flag && !ts_flag && !trig_hit));
endmodule

// File: tb/test_can_bit_timer.sv
`timescale 1ns/1ps
module test_can_bit_timer;
  localparam int TW = 16;
  localparam logic [TW-1:0] MAXV = 16'hFFFF;
  localparam int WDOG = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 0, ctrl_en = 0, lp_mode = 0, sw_rst = 0, lastmb_rdy = 0;
  logic sof_pulse = 0, eof_pulse = 0, status_rd = 0;
  logic freeze_en = 0, cap_eof = 0, tt_mode = 0, ovf_irq_en = 0, ts_irq_en = 0;
  logic [TW-1:0] trig_value = '0;
  logic [TW-1:0] timer_val, stamp_val;
  logic ovf_flag, ts_flag, irq, trig_hit;

  int errors = 0, checks = 0, cycles = 0;
  bit done = 0, cmp_on = 0;

  always #4 clk = ~clk;

  can_bit_timer #(.TW(TW)) i_can_bit_timer (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .ctrl_en(ctrl_en), .lp_mode(lp_mode),
    .sw_rst(sw_rst), .lastmb_rdy(lastmb_rdy), .sof_pulse(sof_pulse), .eof_pulse(eof_pulse),
    .status_rd(status_rd), .freeze_en(freeze_en), .cap_eof(cap_eof), .tt_mode(tt_mode),
    .ovf_irq_en(ovf_irq_en), .ts_irq_en(ts_irq_en), .trig_value(trig_value),
    .timer_val(timer_val), .stamp_val(stamp_val), .ovf_flag(ovf_flag), .ts_flag(ts_flag),
    .irq(irq), .trig_hit(trig_hit)
  );

  // reference model, built from the requirements
  logic [TW-1:0] m_cnt, m_stamp;
  logic m_halt, m_rdy, m_ovf, m_ts, m_hit;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = '0; m_stamp = '0; m_halt = 0; m_rdy = 0; m_ovf = 0; m_ts = 0; m_hit = 0;
    end else begin
      logic clr, adv, oe, cap;
      logic [TW-1:0] old;
      old = m_cnt; adv = 0; oe = 0;
      clr = !ctrl_en || lp_mode || sw_rst || (tt_mode && lastmb_rdy && !m_rdy);
      if (clr) begin m_cnt = '0; m_halt = 0; end
      else if (bit_tick) begin
        if (m_cnt == MAXV) begin
          if (freeze_en) begin
            if (!m_halt) begin oe = 1; m_halt = 1; end
          end else begin m_cnt = '0; adv = 1; oe = 1; m_halt = 0; end
        end else begin m_cnt = m_cnt + 1'b1; adv = 1; end
      end
      cap = cap_eof ? eof_pulse : sof_pulse;
      if (cap) m_stamp = old;
      m_ovf = oe || (m_ovf && !status_rd);
      m_ts  = cap || (m_ts && !status_rd);
      m_hit = tt_mode && adv && (m_cnt == trig_value);
      m_rdy = lastmb_rdy;
    end
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cmp_on && !done) begin
      check("R1 timer_val", timer_val, m_cnt);
      check("R7 stamp_val", stamp_val, m_stamp);
      check("R5 ovf_flag", ovf_flag, m_ovf);
      check("R8 ts_flag", ts_flag, m_ts);
      check("R9 irq", irq, (m_ovf & ovf_irq_en) | (m_ts & ts_irq_en));
      check("R10 trig_hit", trig_hit, m_hit);
    end
  end

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    wait (cycles >= WDOG);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d cycles expected below %0d", cycles, WDOG);
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_C0DE));
    cyc(3);
    // R11: reset state
    check("R11 timer", timer_val, 0);
    check("R11 stamp", stamp_val, 0);
    check("R11 flags", {ovf_flag, ts_flag, irq, trig_hit}, 0);
    rst_n = 1; cyc(5);
    cmp_on = 1;

    // R1: counting
    ctrl_en = 1; bit_tick = 1; cyc(10); bit_tick = 0;
    check("R1 ten ticks", timer_val, 10);
    // R3: software reset wins over tick
    bit_tick = 1; sw_rst = 1; cyc(); sw_rst = 0; bit_tick = 0;
    check("R3 reset wins", timer_val, 0);
    // R2: disable and low power
    bit_tick = 1; cyc(4); ctrl_en = 0; cyc();
    check("R2 disable", timer_val, 0);
    ctrl_en = 1; cyc(3); lp_mode = 1; cyc();
    check("R2 low power", timer_val, 0);
    lp_mode = 0; cyc(5); bit_tick = 0;
    // R4: last mailbox clear only in time-triggered mode
    lastmb_rdy = 1; cyc(); lastmb_rdy = 0; cyc();
    check("R4 ignored tt=0", timer_val, 5);
    tt_mode = 1; trig_value = 16'h7777; lastmb_rdy = 1; cyc(); lastmb_rdy = 0;
    check("R4 tt clear", timer_val, 0);
    tt_mode = 0;
    // R7: capture select
    bit_tick = 1; cyc(6); bit_tick = 0;
    sof_pulse = 1; cyc(); sof_pulse = 0;
    check("R7 sof stamp", stamp_val, 6);
    bit_tick = 1; cyc(); bit_tick = 0; eof_pulse = 1; cyc(); eof_pulse = 0;
    check("R7 eof ignored", stamp_val, 6);
    cap_eof = 1; eof_pulse = 1; cyc(); eof_pulse = 0;
    check("R7 eof stamp", stamp_val, 7);
    sw_rst = 1; eof_pulse = 1; cyc(); sw_rst = 0; eof_pulse = 0;
    check("R7 pre-clear value", stamp_val, 7);
    // R8: read vs simultaneous set
    status_rd = 1; eof_pulse = 1; cyc(); status_rd = 0; eof_pulse = 0;
    check("R8 set wins", ts_flag, 1);
    // R9: masking
    ts_irq_en = 0; #1; check("R9 masked", irq, 0);
    ts_irq_en = 1; #1; check("R9 unmasked", irq, 1);
    status_rd = 1; cyc(); status_rd = 0;
    check("R8 read clears", ts_flag, 0);
    // R10: trigger pulse
    tt_mode = 1; trig_value = 16'd5; sw_rst = 1; cyc(); sw_rst = 0;
    bit_tick = 1; cyc(5);
    check("R10 hit at value", {timer_val, 15'd0, trig_hit}, {16'd5, 15'd0, 1'b1});
    cyc(); check("R10 one cycle", trig_hit, 0);
    bit_tick = 0; tt_mode = 0;
    // R5: wrap
    sw_rst = 1; cyc(); sw_rst = 0; bit_tick = 1; cyc(65535);
    check("R5 at max", timer_val, MAXV);
    cyc(); check("R5 wrapped", timer_val, 0); check("R5 ovf set", ovf_flag, 1);
    bit_tick = 0; status_rd = 1; cyc(); status_rd = 0;
    // R6: freeze
    freeze_en = 1; sw_rst = 1; cyc(); sw_rst = 0; bit_tick = 1; cyc(65536);
    check("R6 frozen", timer_val, MAXV); check("R6 ovf set", ovf_flag, 1);
    status_rd = 1; cyc(); status_rd = 0; cyc(3);
    check("R6 no second ovf", ovf_flag, 0); check("R6 still frozen", timer_val, MAXV);
    sw_rst = 1; cyc(); sw_rst = 0; cyc();
    check("R6 restart", timer_val, 1);
    bit_tick = 0; freeze_en = 0;

    // random phase
    for (int k = 0; k < 4000; k++) begin
      bit_tick   = ($urandom % 4) != 0;
      ctrl_en    = ($urandom % 16) != 0;
      lp_mode    = ($urandom % 32) == 0;
      sw_rst     = ($urandom % 40) == 0;
      if ($urandom % 8 == 0) lastmb_rdy = ~lastmb_rdy;
      sof_pulse  = ($urandom % 8) == 0;
      eof_pulse  = ($urandom % 8) == 0;
      status_rd  = ($urandom % 10) == 0;
      if ($urandom % 64 == 0) begin
        freeze_en = $urandom; cap_eof = $urandom; tt_mode = $urandom;
        trig_value = 16'($urandom % 24);
      end
      ovf_irq_en = $urandom; ts_irq_en = $urandom;
      cyc();
    end
    bit_tick = 0; sw_rst = 0; sof_pulse = 0; eof_pulse = 0; status_rd = 0;
    cyc(2);
    finish_run();
  end
endmodule